// File: doc/BRIEF.md
# Interrupt Controller Register Interface

This block is the memory-mapped register file that sits in front of a platform interrupt arbiter. A simple 32-bit bus (address, write data, write strobe, read strobe, read data) reaches four address windows: a per-source priority array, a read-only view of the pending bits, per-context enable bitmaps and a per-context control page holding a priority threshold and a claim/complete register.

The registered contents are driven to the arbiter as flat vectors. The arbiter returns the current winning source ID for each context. Reading a context's claim/complete register returns that ID and, when it is nonzero, sends a one-cycle claim pulse back to the arbiter. Writing the same register sends a completion pulse that carries the written ID. Out-of-range threshold and completion writes are dropped without any report. Unmapped or malformed addresses read as zero, and writes to them change nothing.

Every window base, both strides, the source count, the context count, the priority width and the highest legal threshold are elaboration parameters. Source ID 0 means "no interrupt".

Top module: `irqc_csr_if`

## Requirements
- R1: Only word-aligned addresses (`bus_addr[1:0]==0`) decode. A read of an unaligned or unmapped address returns 0, and a write to one changes no register and produces no pulse.
- R2: The priority word at `PRIO_BASE + 4*k` belongs to source k+1, for k from 0 to NSRC-2. A write keeps only `wdata[PRIO_W-1:0]`. Reads return that value zero-extended, and it appears on `prio_o[(k+1)*PRIO_W +: PRIO_W]`.
- R3: The pending window at `PEND_BASE` spans ceil(NSRC/32) words. Bit j of word w reads `pend_i[32*w+j]`, and bits at or above NSRC read 0. Writes to the window are ignored.
- R4: Enable word w of context c lives at `EN_BASE + c*EN_STRIDE + 4*w`. Bit j controls source 32*w+j and appears on `en_o[c*NSRC + 32*w + j]`. Bits at or above NSRC read 0. Words with w at or above ceil(NSRC/32) read 0 and ignore writes. Contexts do not share storage.
- R5: The threshold of context c is at `CTX_BASE + c*CTX_STRIDE`. A write takes effect only when the full 32-bit value is at most MAX_PRIO. Otherwise the old value stays. The threshold appears on `thr_o[c*PRIO_W +: PRIO_W]`.
- R6: A read of `CTX_BASE + c*CTX_STRIDE + 4` returns `win_id_i[c*ID_W +: ID_W]` sampled at the read strobe. When that ID is nonzero, `claim_o[c]` pulses for exactly one cycle, alongside the read data, with `claim_id_o` equal to that ID.
- R7: A write to that same register pulses `cmpl_o[c]` for one cycle with `cmpl_id_o = wdata[ID_W-1:0]` when wdata < NSRC. Larger values produce no pulse.
- R8: Any offset inside a context page other than 0 and 4 is invalid (R1 rules). Context pages and enable blocks beyond NCTX are unmapped.
- R9: `bus_rdata` carries read data in the cycle after the read strobe and is 0 in every other cycle.
- R10: When read and write strobes coincide, the read returns the contents from before the write. On a claim/complete register both the claim pulse and the completion pulse are issued in the same cycle.
- R11: After reset every priority, enable and threshold is 0, `bus_rdata` is 0 and no pulse is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per access |
| bus_re | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_re` |
| pend_i | input | NSRC | Pending bit per source, from the arbiter |
| win_id_i | input | NCTX*ID_W | Winning source ID per context, from the arbiter |
| prio_o | output | NSRC*PRIO_W | Priority per source (slot 0 unused, always 0) |
| en_o | output | NCTX*NSRC | Enable bit per context and source |
| thr_o | output | NCTX*PRIO_W | Threshold per context |
| claim_o | output | NCTX | One-cycle claim pulse per context |
| claim_id_o | output | ID_W | ID being claimed |
| cmpl_o | output | NCTX | One-cycle completion pulse per context |
| cmpl_id_o | output | ID_W | ID being completed |

## Verification
The two functions that can land in one cycle are a claim and a completion on the same context register, or a read and a write of any stored register. The bench drives `bus_re` and `bus_we` together on one address. It expects the claim pulse (carrying the arbiter's ID) and the completion pulse (carrying the written ID) in the same following cycle, with the read data equal to the ID the arbiter offered. On a threshold register it checks that the combined access returns the old value and that a later read shows the new one.

// File: rtl/irqc_csr_pkg.sv
package irqc_csr_pkg;

    // Which register window an access falls into
    typedef enum logic [2:0] {
        RG_NONE = 3'd0,
        RG_PRIO = 3'd1,
        RG_PEND = 3'd2,
        RG_EN   = 3'd3,
        RG_THR  = 3'd4,
        RG_CLM  = 3'd5
    } irqc_rg_e;

endpackage

// File: rtl/irqc_addr_dec.sv
module irqc_addr_dec
    import irqc_csr_pkg::*;
#(
    parameter int unsigned ADDR_W     = 24,
    parameter int unsigned NSRC       = 40,
    parameter int unsigned NCTX       = 2,
    parameter int unsigned PRIO_BASE  = 32'h0000_0000,
    parameter int unsigned PEND_BASE  = 32'h0000_1000,
    parameter int unsigned EN_BASE    = 32'h0000_2000,
    parameter int unsigned EN_STRIDE  = 32'h0000_0080,
    parameter int unsigned CTX_BASE   = 32'h0020_0000,
    parameter int unsigned CTX_STRIDE = 32'h0000_1000,
    localparam int unsigned ID_W  = $clog2(NSRC),
    localparam int unsigned NWORD = (NSRC + 31) / 32,
    localparam int unsigned WIW   = (NWORD > 1) ? $clog2(NWORD) : 1,
    localparam int unsigned CIW   = (NCTX > 1) ? $clog2(NCTX) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output irqc_rg_e          kind,
    output logic [ID_W-1:0]   src_idx,
    output logic [WIW-1:0]    word_idx,
    output logic [CIW-1:0]    ctx_idx
);

    localparam int unsigned PRIO_BYTES = (NSRC - 1) * 4;
    localparam int unsigned PEND_BYTES = NWORD * 4;
    localparam int unsigned EN_SPAN    = NCTX * EN_STRIDE;
    localparam int unsigned CTX_SPAN   = NCTX * CTX_STRIDE;
    localparam int unsigned EN_SH      = $clog2(EN_STRIDE);
    localparam int unsigned CTX_SH     = $clog2(CTX_STRIDE);

    logic [31:0] a_w;
    logic [31:0] p_off;
    logic [31:0] q_off;
    logic [31:0] e_off;
    logic [31:0] c_off;
    logic [31:0] e_in;
    logic [31:0] c_in;

    assign a_w   = 32'(addr);
    assign p_off = a_w - PRIO_BASE;
    assign q_off = a_w - PEND_BASE;
    assign e_off = a_w - EN_BASE;
    assign c_off = a_w - CTX_BASE;
    // Strides are powers of two: the in-page offset is a mask
    assign e_in  = e_off & (EN_STRIDE - 1);
    assign c_in  = c_off & (CTX_STRIDE - 1);

    always_comb begin
        kind     = RG_NONE;
        src_idx  = '0;
        word_idx = '0;
        ctx_idx  = '0;
        if (a_w[1:0] == 2'b00) begin
            if (a_w >= PRIO_BASE && p_off < PRIO_BYTES) begin
                kind    = RG_PRIO;
                src_idx = ID_W'((p_off >> 2) + 1);
            end else if (a_w >= PEND_BASE && q_off < PEND_BYTES) begin
                kind     = RG_PEND;
                word_idx = WIW'(q_off >> 2);
            end else if (a_w >= EN_BASE && e_off < EN_SPAN) begin
                ctx_idx  = CIW'(e_off >> EN_SH);
                word_idx = WIW'(e_in >> 2);
                if ((e_in >> 2) < NWORD) begin
                    kind = RG_EN;
                end
            end else if (a_w >= CTX_BASE && c_off < CTX_SPAN) begin
                ctx_idx = CIW'(c_off >> CTX_SH);
                if (c_in == 32'd0) begin
                    kind = RG_THR;
                end else if (c_in == 32'd4) begin
                    kind = RG_CLM;
                end
            end
        end
    end

endmodule

// File: rtl/irqc_rd_mux.sv
module irqc_rd_mux
    import irqc_csr_pkg::*;
#(
    parameter int unsigned NSRC   = 40,
    parameter int unsigned NCTX   = 2,
    parameter int unsigned PRIO_W = 3,
    localparam int unsigned ID_W  = $clog2(NSRC),
    localparam int unsigned NWORD = (NSRC + 31) / 32,
    localparam int unsigned WIW   = (NWORD > 1) ? $clog2(NWORD) : 1,
    localparam int unsigned CIW   = (NCTX > 1) ? $clog2(NCTX) : 1
) (
    input  irqc_rg_e                       kind,
    input  logic [ID_W-1:0]                src_idx,
    input  logic [WIW-1:0]                 word_idx,
    input  logic [CIW-1:0]                 ctx_idx,
    input  logic [NSRC-1:0][PRIO_W-1:0]    prio,
    input  logic [NCTX-1:0][NSRC-1:0]      en,
    input  logic [NCTX-1:0][PRIO_W-1:0]    thr,
    input  logic [NSRC-1:0]                pend,
    input  logic [NCTX-1:0][ID_W-1:0]      win,
    output logic [31:0]                    rd
);

    always_comb begin
        rd = '0;
        unique case (kind)
            RG_PRIO: rd = 32'(prio[src_idx]);
            RG_PEND: begin
                for (int i = 0; i < 32; i++) begin
                    if (int'(word_idx) * 32 + i < int'(NSRC)) begin
                        rd[i] = pend[ID_W'(int'(word_idx) * 32 + i)];
                    end
                end
            end
            RG_EN: begin
                for (int i = 0; i < 32; i++) begin
                    if (int'(word_idx) * 32 + i < int'(NSRC)) begin
                        rd[i] = en[ctx_idx][ID_W'(int'(word_idx) * 32 + i)];
                    end
                end
            end
            RG_THR:  rd = 32'(thr[ctx_idx]);
            RG_CLM:  rd = 32'(win[ctx_idx]);
            default: rd = '0;
        endcase
    end

endmodule

// File: rtl/irqc_csr_if.sv
module irqc_csr_if
    import irqc_csr_pkg::*;
#(
    parameter int unsigned ADDR_W     = 24,
    parameter int unsigned NSRC       = 40,
    parameter int unsigned NCTX       = 2,
    parameter int unsigned PRIO_W     = 3,
    parameter int unsigned MAX_PRIO   = 7,
    parameter int unsigned PRIO_BASE  = 32'h0000_0000,
    parameter int unsigned PEND_BASE  = 32'h0000_1000,
    parameter int unsigned EN_BASE    = 32'h0000_2000,
    parameter int unsigned EN_STRIDE  = 32'h0000_0080,
    parameter int unsigned CTX_BASE   = 32'h0020_0000,
    parameter int unsigned CTX_STRIDE = 32'h0000_1000,
    localparam int unsigned ID_W  = $clog2(NSRC),
    localparam int unsigned NWORD = (NSRC + 31) / 32,
    localparam int unsigned WIW   = (NWORD > 1) ? $clog2(NWORD) : 1,
    localparam int unsigned CIW   = (NCTX > 1) ? $clog2(NCTX) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [31:0]             bus_wdata,
    input  logic                    bus_we,
    input  logic                    bus_re,
    output logic [31:0]             bus_rdata,
    input  logic [NSRC-1:0]         pend_i,
    input  logic [NCTX*ID_W-1:0]    win_id_i,
    output logic [NSRC*PRIO_W-1:0]  prio_o,
    output logic [NCTX*NSRC-1:0]    en_o,
    output logic [NCTX*PRIO_W-1:0]  thr_o,
    output logic [NCTX-1:0]         claim_o,
    output logic [ID_W-1:0]         claim_id_o,
    output logic [NCTX-1:0]         cmpl_o,
    output logic [ID_W-1:0]         cmpl_id_o
);

    typedef struct packed {
        logic [NSRC-1:0][PRIO_W-1:0] prio;
        logic [NCTX-1:0][NSRC-1:0]   en;
        logic [NCTX-1:0][PRIO_W-1:0] thr;
        logic [31:0]                 rdata;
        logic [NCTX-1:0]             clm;
        logic [ID_W-1:0]             clm_id;
        logic [NCTX-1:0]             cmp;
        logic [ID_W-1:0]             cmp_id;
    } csr_st_t;

    csr_st_t st_d, st_q;

    irqc_rg_e                  dec_kind;
    logic [ID_W-1:0]           dec_src;
    logic [WIW-1:0]            dec_word;
    logic [CIW-1:0]            dec_ctx;
    logic [31:0]               rd_val;
    logic [NCTX-1:0][ID_W-1:0] win_a;

    assign win_a = win_id_i;

    irqc_addr_dec #(
        .ADDR_W    (ADDR_W),
        .NSRC      (NSRC),
        .NCTX      (NCTX),
        .PRIO_BASE (PRIO_BASE),
        .PEND_BASE (PEND_BASE),
        .EN_BASE   (EN_BASE),
        .EN_STRIDE (EN_STRIDE),
        .CTX_BASE  (CTX_BASE),
        .CTX_STRIDE(CTX_STRIDE)
    ) u_dec (
        .addr    (bus_addr),
        .kind    (dec_kind),
        .src_idx (dec_src),
        .word_idx(dec_word),
        .ctx_idx (dec_ctx)
    );

    irqc_rd_mux #(
        .NSRC  (NSRC),
        .NCTX  (NCTX),
        .PRIO_W(PRIO_W)
    ) u_rd (
        .kind    (dec_kind),
        .src_idx (dec_src),
        .word_idx(dec_word),
        .ctx_idx (dec_ctx),
        .prio    (st_q.prio),
        .en      (st_q.en),
        .thr     (st_q.thr),
        .pend    (pend_i),
        .win     (win_a),
        .rd      (rd_val)
    );

    always_comb begin
        st_d        = st_q;
        st_d.rdata  = '0;
        st_d.clm    = '0;
        st_d.clm_id = '0;
        st_d.cmp    = '0;
        st_d.cmp_id = '0;

        // Read side uses pre-write state, so a combined access sees old data
        if (bus_re) begin
            st_d.rdata = rd_val;
            if (dec_kind == RG_CLM && win_a[dec_ctx] != '0) begin
                st_d.clm[dec_ctx] = 1'b1;
                st_d.clm_id       = win_a[dec_ctx];
            end
        end

        if (bus_we) begin
            unique case (dec_kind)
                RG_PRIO: st_d.prio[dec_src] = bus_wdata[PRIO_W-1:0];
                RG_EN: begin
                    for (int i = 0; i < 32; i++) begin
                        if (int'(dec_word) * 32 + i < int'(NSRC)) begin
                            st_d.en[dec_ctx][ID_W'(int'(dec_word) * 32 + i)] = bus_wdata[i];
                        end
                    end
                end
                RG_THR: begin
                    if (bus_wdata <= MAX_PRIO) begin
                        st_d.thr[dec_ctx] = bus_wdata[PRIO_W-1:0];
                    end
                end
                RG_CLM: begin
                    if (bus_wdata < NSRC) begin
                        st_d.cmp[dec_ctx] = 1'b1;
                        st_d.cmp_id       = bus_wdata[ID_W-1:0];
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata  = st_q.rdata;
    assign prio_o     = st_q.prio;
    assign en_o       = st_q.en;
    assign thr_o      = st_q.thr;
    assign claim_o    = st_q.clm;
    assign claim_id_o = st_q.clm_id;
    assign cmpl_o     = st_q.cmp;
    assign cmpl_id_o  = st_q.cmp_id;

endmodule

// File: rtl/irqc_csr_if_chk.sv
module irqc_csr_if_chk #(
    parameter int unsigned NSRC   = 40,
    parameter int unsigned NCTX   = 2,
    parameter int unsigned PRIO_W = 3,
    localparam int unsigned ID_W  = $clog2(NSRC)
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    bus_we,
    input logic                    bus_re,
    input logic [31:0]             bus_rdata,
    input logic [NSRC*PRIO_W-1:0]  prio_o,
    input logic [NCTX*PRIO_W-1:0]  thr_o,
    input logic [NCTX-1:0]         claim_o,
    input logic [ID_W-1:0]         claim_id_o,
    input logic [NCTX-1:0]         cmpl_o,
    input logic [ID_W-1:0]         cmpl_id_o
);

    // R2
    prio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> $stable(prio_o));

    // R5
    thr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> $stable(thr_o));

    // R6
    claim_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(claim_o));

    // R6
    claim_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (claim_o != '0) |-> ($past(bus_re) && claim_id_o != '0));

    // R7
    cmpl_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmpl_o != '0) |-> ($past(bus_we) && 32'(cmpl_id_o) < NSRC && $onehot0(cmpl_o)));

    // R9
    rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_re |=> (bus_rdata == '0));

    // R6
    claim_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (claim_o != '0) && !bus_re |=> (claim_o == '0));

endmodule

bind irqc_csr_if irqc_csr_if_chk #(
    .NSRC  (NSRC),
    .NCTX  (NCTX),
    .PRIO_W(PRIO_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .bus_rdata (bus_rdata),
    .prio_o    (prio_o),
    .thr_o     (thr_o),
    .claim_o   (claim_o),
    .claim_id_o(claim_id_o),
    .cmpl_o    (cmpl_o),
    .cmpl_id_o (cmpl_id_o)
);

// File: tb/irqc_csr_if_test.sv
module irqc_csr_if_test;

    localparam int NSRC = 40;
    localparam int NCTX = 2;
    localparam int PW   = 3;
    localparam int IDW  = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [23:0]       bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic              bus_we = 1'b0;
    logic              bus_re = 1'b0;
    logic [31:0]       bus_rdata;
    logic [NSRC-1:0]   pend_i = '0;
    logic [NCTX*IDW-1:0] win_id_i = '0;
    logic [NSRC*PW-1:0] prio_o;
    logic [NCTX*NSRC-1:0] en_o;
    logic [NCTX*PW-1:0] thr_o;
    logic [NCTX-1:0]   claim_o;
    logic [IDW-1:0]    claim_id_o;
    logic [NCTX-1:0]   cmpl_o;
    logic [IDW-1:0]    cmpl_id_o;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    irqc_csr_if uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .pend_i(pend_i), .win_id_i(win_id_i), .prio_o(prio_o), .en_o(en_o),
        .thr_o(thr_o), .claim_o(claim_o), .claim_id_o(claim_id_o),
        .cmpl_o(cmpl_o), .cmpl_id_o(cmpl_id_o)
    );

    typedef struct packed {
        logic        we;
        logic        re;
        logic [23:0] addr;
        logic [31:0] wdata;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 32;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 1'b0, 24'h000000, 32'h0000000D, 32'h0,        8'd2},  // R2
        '{1'b0, 1'b1, 24'h000000, 32'h0,        32'h5,        8'd2},
        '{1'b1, 1'b0, 24'h000098, 32'h3,        32'h0,        8'd2},
        '{1'b0, 1'b1, 24'h000098, 32'h0,        32'h3,        8'd2},
        '{1'b0, 1'b1, 24'h00009C, 32'h0,        32'h0,        8'd1},  // R1
        '{1'b1, 1'b0, 24'h000001, 32'h7,        32'h0,        8'd1},
        '{1'b0, 1'b1, 24'h000004, 32'h0,        32'h0,        8'd1},
        '{1'b1, 1'b0, 24'h001000, 32'hFFFFFFFF, 32'h0,        8'd3},  // R3
        '{1'b0, 1'b1, 24'h001000, 32'h0,        32'h00000003, 8'd3},
        '{1'b0, 1'b1, 24'h001004, 32'h0,        32'h000000A5, 8'd3},
        '{1'b0, 1'b1, 24'h001008, 32'h0,        32'h0,        8'd3},
        '{1'b1, 1'b0, 24'h002000, 32'hFFFFFFFF, 32'h0,        8'd4},  // R4
        '{1'b0, 1'b1, 24'h002000, 32'h0,        32'hFFFFFFFF, 8'd4},
        '{1'b1, 1'b0, 24'h002004, 32'hFFFFFFFF, 32'h0,        8'd4},
        '{1'b0, 1'b1, 24'h002004, 32'h0,        32'h000000FF, 8'd4},
        '{1'b1, 1'b0, 24'h002008, 32'h00001234, 32'h0,        8'd4},
        '{1'b0, 1'b1, 24'h002008, 32'h0,        32'h0,        8'd4},
        '{1'b1, 1'b0, 24'h002080, 32'hA5A5A5A5, 32'h0,        8'd4},
        '{1'b0, 1'b1, 24'h002080, 32'h0,        32'hA5A5A5A5, 8'd4},
        '{1'b0, 1'b1, 24'h002000, 32'h0,        32'hFFFFFFFF, 8'd4},
        '{1'b1, 1'b0, 24'h200000, 32'h4,        32'h0,        8'd5},  // R5
        '{1'b0, 1'b1, 24'h200000, 32'h0,        32'h4,        8'd5},
        '{1'b1, 1'b0, 24'h200000, 32'h8,        32'h0,        8'd5},
        '{1'b0, 1'b1, 24'h200000, 32'h0,        32'h4,        8'd5},
        '{1'b1, 1'b0, 24'h200000, 32'h7,        32'h0,        8'd5},
        '{1'b0, 1'b1, 24'h200000, 32'h0,        32'h7,        8'd5},
        '{1'b1, 1'b0, 24'h201000, 32'h2,        32'h0,        8'd5},
        '{1'b0, 1'b1, 24'h201000, 32'h0,        32'h2,        8'd5},
        '{1'b1, 1'b0, 24'h200008, 32'h5,        32'h0,        8'd8},  // R8
        '{1'b0, 1'b1, 24'h200008, 32'h0,        32'h0,        8'd8},
        '{1'b0, 1'b1, 24'h200000, 32'h0,        32'h7,        8'd8},
        '{1'b0, 1'b1, 24'h202000, 32'h0,        32'h0,        8'd8}
    };

    task automatic chk(input string req, input logic [79:0] act, input logic [79:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic acc(input logic we, input logic re, input logic [23:0] addr,
                       input logic [31:0] wd);
        @(negedge clk);
        bus_we = we; bus_re = re; bus_addr = addr; bus_wdata = wd;
        @(negedge clk);
        bus_we = 1'b0; bus_re = 1'b0;
    endtask

    task automatic finish_run;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #2_000_000;
        total++;
        bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        pend_i = 40'hA5_0000_0003;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11 rdata", 80'(bus_rdata), 80'h0);
        chk("R11 prio", 80'(prio_o == '0), 80'h1);
        chk("R11 en", 80'(en_o), 80'h0);
        chk("R11 thr", 80'(thr_o), 80'h0);
        chk("R11 pulses", 80'({claim_o, cmpl_o}), 80'h0);

        for (int i = 0; i < NV; i++) begin
            acc(VEC[i].we, VEC[i].re, VEC[i].addr, VEC[i].wdata);
            if (VEC[i].re) begin
                chk($sformatf("R%0d vec%0d", VEC[i].req, i), 80'(bus_rdata), 80'(VEC[i].exp));
            end else begin
                // R9 no read data after a write-only access
                chk($sformatf("R9 vec%0d", i), 80'(bus_rdata), 80'h0);
            end
        end

        // R2 priorities on the output bus
        chk("R2 prio src1", 80'(prio_o[1*PW +: PW]), 80'h5);
        chk("R2 prio src39", 80'(prio_o[39*PW +: PW]), 80'h3);
        chk("R1 prio src2 untouched", 80'(prio_o[2*PW +: PW]), 80'h0);
        // R4 enable bitmaps per context
        chk("R4 en ctx0", 80'(en_o[0 +: NSRC]), 80'hFF_FFFF_FFFF);
        chk("R4 en ctx1", 80'(en_o[NSRC +: NSRC]), 80'h00_A5A5_A5A5);
        // R5 thresholds on the output bus
        chk("R5 thr", 80'(thr_o), 80'({3'd2, 3'd7}));

        // R6 claim
        win_id_i = {6'd33, 6'd17};
        acc(1'b0, 1'b1, 24'h200004, 32'h0);
        chk("R6 claim rdata", 80'(bus_rdata), 80'd17);
        chk("R6 claim strobe", 80'({claim_o, claim_id_o}), 80'({2'b01, 6'd17}));
        @(negedge clk);
        chk("R6 single pulse", 80'(claim_o), 80'h0);
        chk("R9 rdata idle", 80'(bus_rdata), 80'h0);
        acc(1'b0, 1'b1, 24'h201004, 32'h0);
        chk("R6 claim ctx1", 80'({bus_rdata[7:0], claim_o, claim_id_o}), 80'({8'd33, 2'b10, 6'd33}));
        win_id_i = {6'd33, 6'd0};
        acc(1'b0, 1'b1, 24'h200004, 32'h0);
        chk("R6 zero id no claim", 80'({bus_rdata, 2'b00, claim_o}), 80'h0);

        // R7 complete
        acc(1'b1, 1'b0, 24'h201004, 32'd39);
        chk("R7 complete", 80'({cmpl_o, cmpl_id_o, claim_o}), 80'({2'b10, 6'd39, 2'b00}));
        acc(1'b1, 1'b0, 24'h201004, 32'd40);
        chk("R7 out of range", 80'(cmpl_o), 80'h0);

        // R10 read and write together
        win_id_i = {6'd0, 6'd9};
        acc(1'b1, 1'b1, 24'h200004, 32'd5);
        chk("R10 rdata", 80'(bus_rdata), 80'd9);
        chk("R10 claim", 80'({claim_o, claim_id_o}), 80'({2'b01, 6'd9}));
        chk("R10 complete", 80'({cmpl_o, cmpl_id_o}), 80'({2'b01, 6'd5}));
        acc(1'b1, 1'b1, 24'h200000, 32'd3);
        chk("R10 old thr", 80'(bus_rdata), 80'd7);
        acc(1'b0, 1'b1, 24'h200000, 32'h0);
        chk("R10 new thr", 80'(bus_rdata), 80'd3);

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule